// File: doc/BRIEF.md
# FSM Conformance Test Sequencer

This block is an on-chip test controller for a small Mealy machine with two input symbols and a one-bit output. It drives the machine under test through a port set of its own: a clear pulse that returns the machine to its start state, a symbol bit and a step strobe. It then reads back the registered output bit one cycle after each step. A lock-step golden copy of the reference machine runs inside the controller and gives the expected output for every step.

A run is started with a mode select. The mode picks one of four stored suites: a single transition tour, distinguishing-sequence cases, characterizing-set cases, or unique-input-output (UIO) cases. Every case is a clear, then a setup prefix that reaches the source state, then the transition under test, then an identifying suffix. Setup outputs are not compared. A mismatch on a checked transition is reported as an output fault. A mismatch in the suffix is reported as a transfer fault. The first failing case index is held, and the run stops there.

The reference machine has states s1, s2 and s3 and the symbols a and b. From s1, a gives output 0 and stays in s1, and b gives 1 and moves to s2. From s2, a gives 1 and stays in s2, and b gives 1 and moves to s3. From s3, a gives 0 and stays in s3, and b gives 0 and moves to s1.

Top module: `fsm_conf_seq`

## Requirements
- R1: While reset is held and just after it, busy_o, done_o, pass_o, mut_clr_o and mut_step_o are 0 and fault_code_o is 0.
- R2: Each case starts with exactly one mut_clr_o pulse, and mut_step_o follows in the next cycle. A passing run issues 1 clear in tour mode (mode 0), 6 in distinguishing mode (mode 1), 12 in characterizing mode (mode 2) and 6 in UIO mode (mode 3).
- R3: mut_step_o is a single-cycle strobe. It never occurs in two consecutive cycles and never together with mut_clr_o. mut_sym_o carries the symbol, with a = 0 and b = 1.
- R4: Tour mode applies the symbols a,b,a,b,a,b once after one clear, checks all six outputs, and passes a machine whose only fault is a wrong next state.
- R5: Distinguishing mode runs six cases of 24 steps in total and passes a correct machine. A machine whose s3-on-b transition stays in s3 fails at case 5 with a transfer fault.
- R6: Characterizing mode runs each transition case with suffix a and then with suffix b, giving 12 cases and 36 steps. The same transfer fault fails at case 11.
- R7: UIO mode uses suffix ab for s1, a for s2 and b for s3, giving 6 cases and 20 steps. The same transfer fault fails at case 5.
- R8: A wrong output on the transition under test gives fault_code_o = 1 (output fault). A machine that outputs 1 for s1 on a fails at case 0 with code 1 in every mode.
- R9: A wrong output during the identifying suffix gives fault_code_o = 2 (transfer fault).
- R10: At the first mismatch the run stops: done_o rises with pass_o = 0, and no further step or clear strobes occur. busy_o and done_o are never high together.
- R11: start_i is ignored while busy_o is high. A second start with a different mode does not alter the steps or the result of the run in progress.
- R12: When done_o and pass_o are both 1, fault_code_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Starts a run from idle or done |
| mode_i | input | 2 | Suite select: 0 tour, 1 distinguishing, 2 characterizing, 3 UIO |
| mut_clr_o | output | 1 | Clear pulse returning the machine under test to s1 |
| mut_sym_o | output | 1 | Input symbol, a = 0, b = 1 |
| mut_step_o | output | 1 | Step strobe applying mut_sym_o |
| mut_out_i | input | 1 | Registered output bit of the machine under test |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | Run finished, result valid |
| pass_o | output | 1 | All cases matched |
| fault_code_o | output | 2 | 0 none, 1 output fault, 2 transfer fault |
| fail_case_o | output | 4 | Index of the first failing case |

## Verification
The checker enforces the strobe discipline on every cycle: single-cycle steps, a step right after each clear, no strobes after completion, busy and done never together, and a fault code that matches the pass bit. Only the bench's scenarios can show that the right number of cases and steps are issued per mode, that the tour symbol order is correct, and that injected output and transfer faults give the expected code and case index. The same holds for the tour's blindness to the transfer fault and for the rejection of a second start mid-run.

// File: rtl/fsm_conf_pkg.sv
`timescale 1ns/1ps
package fsm_conf_pkg;
  localparam int SEQ_MAX  = 6;
  localparam int IDX_W    = $clog2(SEQ_MAX + 1);
  localparam int CASE_MAX = 12;
  localparam int CASE_W   = $clog2(CASE_MAX);

  typedef enum logic [1:0] {ST_S1, ST_S2, ST_S3} mstate_e;
  typedef enum logic [1:0] {MODE_TOUR = 2'd0, MODE_DS = 2'd1, MODE_W = 2'd2, MODE_UIO = 2'd3} mode_e;
  localparam logic [1:0] FC_NONE     = 2'd0;
  localparam logic [1:0] FC_OUTPUT   = 2'd1;
  localparam logic [1:0] FC_TRANSFER = 2'd2;

  // seq is left-aligned: step k applies seq[SEQ_MAX-1-k]
  typedef struct packed {
    logic [IDX_W-1:0]   len;
    logic [IDX_W-1:0]   chk_lo;
    logic [IDX_W-1:0]   chk_hi;
    logic [SEQ_MAX-1:0] seq;
  } case_t;

  function automatic case_t mk_case(int len, int lo, int hi, logic [SEQ_MAX-1:0] s);
    case_t c;
    c.len    = IDX_W'(len);
    c.chk_lo = IDX_W'(lo);
    c.chk_hi = IDX_W'(hi);
    c.seq    = s;
    return c;
  endfunction
endpackage

// File: rtl/fsm_mealy_ref.sv
`timescale 1ns/1ps
module fsm_mealy_ref import fsm_conf_pkg::*; #(
  parameter int FAULT = 0  // 0 none, 1 s1/a outputs 1, 2 s3/b stays in s3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic sym_i,
  input  logic step_i,
  output logic out_o
);
  mstate_e st_q, st_d;
  logic    o_d, out_q;

  always_comb begin
    st_d = st_q;
    o_d  = 1'b0;
    unique case (st_q)
      ST_S1: if (sym_i) begin o_d = 1'b1; st_d = ST_S2; end
             else       begin o_d = 1'b0; st_d = ST_S1; end
      ST_S2: if (sym_i) begin o_d = 1'b1; st_d = ST_S3; end
             else       begin o_d = 1'b1; st_d = ST_S2; end
      ST_S3: if (sym_i) begin o_d = 1'b0; st_d = ST_S1; end
             else       begin o_d = 1'b0; st_d = ST_S3; end
      default: begin o_d = 1'b0; st_d = ST_S1; end
    endcase
    if (FAULT == 1 && st_q == ST_S1 && !sym_i) o_d = 1'b1;
    if (FAULT == 2 && st_q == ST_S3 && sym_i)  st_d = ST_S3;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_S1;
      out_q <= 1'b0;
    end else if (clr_i) begin
      st_q  <= ST_S1;
      out_q <= 1'b0;
    end else if (step_i) begin
      st_q  <= st_d;
      out_q <= o_d;
    end
  end

  assign out_o = out_q;
endmodule

// File: rtl/fsm_suite_rom.sv
`timescale 1ns/1ps
module fsm_suite_rom import fsm_conf_pkg::*; (
  input  mode_e             mode_i,
  input  logic [CASE_W-1:0] idx_i,
  output case_t             rec_o,
  output logic [CASE_W-1:0] last_idx_o
);
  int unsigned k;

  always_comb begin
    k          = int'(idx_i);
    rec_o      = mk_case(6, 0, 5, 6'b010101);
    last_idx_o = '0;
    unique case (mode_i)
      MODE_TOUR: begin
        last_idx_o = CASE_W'(0);
        rec_o      = mk_case(6, 0, 5, 6'b010101);  // ababab
      end
      MODE_DS: begin
        last_idx_o = CASE_W'(5);
        case (k)
          0: rec_o = mk_case(3, 0, 0, 6'b001000);
          1: rec_o = mk_case(3, 0, 0, 6'b101000);
          2: rec_o = mk_case(4, 1, 1, 6'b100100);
          3: rec_o = mk_case(4, 1, 1, 6'b110100);
          4: rec_o = mk_case(5, 2, 2, 6'b110010);
          default: rec_o = mk_case(5, 2, 2, 6'b111010);
        endcase
      end
      MODE_W: begin
        last_idx_o = CASE_W'(11);
        case (k)
          0:  rec_o = mk_case(2, 0, 0, 6'b000000);
          1:  rec_o = mk_case(2, 0, 0, 6'b010000);
          2:  rec_o = mk_case(2, 0, 0, 6'b100000);
          3:  rec_o = mk_case(2, 0, 0, 6'b110000);
          4:  rec_o = mk_case(3, 1, 1, 6'b100000);
          5:  rec_o = mk_case(3, 1, 1, 6'b101000);
          6:  rec_o = mk_case(3, 1, 1, 6'b110000);
          7:  rec_o = mk_case(3, 1, 1, 6'b111000);
          8:  rec_o = mk_case(4, 2, 2, 6'b110000);
          9:  rec_o = mk_case(4, 2, 2, 6'b110100);
          10: rec_o = mk_case(4, 2, 2, 6'b111000);
          default: rec_o = mk_case(4, 2, 2, 6'b111100);
        endcase
      end
      MODE_UIO: begin
        last_idx_o = CASE_W'(5);
        case (k)
          0: rec_o = mk_case(3, 0, 0, 6'b001000);
          1: rec_o = mk_case(2, 0, 0, 6'b100000);
          2: rec_o = mk_case(3, 1, 1, 6'b100000);
          3: rec_o = mk_case(3, 1, 1, 6'b111000);
          4: rec_o = mk_case(4, 2, 2, 6'b110100);
          default: rec_o = mk_case(5, 2, 2, 6'b111010);
        endcase
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/fsm_conf_seq.sv
`timescale 1ns/1ps
module fsm_conf_seq import fsm_conf_pkg::*; (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [1:0]        mode_i,
  output logic              mut_clr_o,
  output logic              mut_sym_o,
  output logic              mut_step_o,
  input  logic              mut_out_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              pass_o,
  output logic [1:0]        fault_code_o,
  output logic [CASE_W-1:0] fail_case_o
);
  typedef enum logic [2:0] {SQ_IDLE, SQ_CLR, SQ_STEP, SQ_CMP, SQ_DONE} sq_e;

  sq_e               st_q;
  mode_e             mode_q;
  logic [CASE_W-1:0] case_q, last_idx, fail_q;
  logic [IDX_W-1:0]  step_q, sym_pos;
  logic [1:0]        fcode_q;
  logic              pass_q, gold_out;
  logic              mism, in_setup, in_chk, last_step, last_case;
  case_t             rec;

  fsm_suite_rom u_rom (
    .mode_i    (mode_q),
    .idx_i     (case_q),
    .rec_o     (rec),
    .last_idx_o(last_idx)
  );

  fsm_mealy_ref #(.FAULT(0)) u_gold (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (mut_clr_o),
    .sym_i (mut_sym_o),
    .step_i(mut_step_o),
    .out_o (gold_out)
  );

  assign sym_pos    = IDX_W'(SEQ_MAX - 1) - step_q;
  assign mut_sym_o  = rec.seq[sym_pos];
  assign mut_clr_o  = (st_q == SQ_CLR);
  assign mut_step_o = (st_q == SQ_STEP);

  assign mism      = mut_out_i != gold_out;
  assign in_setup  = step_q < rec.chk_lo;
  assign in_chk    = step_q <= rec.chk_hi;
  assign last_step = step_q == (rec.len - IDX_W'(1));
  assign last_case = case_q == last_idx;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= SQ_IDLE;
      mode_q  <= MODE_TOUR;
      case_q  <= '0;
      step_q  <= '0;
      pass_q  <= 1'b0;
      fcode_q <= FC_NONE;
      fail_q  <= '0;
    end else begin
      unique case (st_q)
        SQ_IDLE, SQ_DONE: if (start_i) begin
          mode_q  <= mode_e'(mode_i);
          case_q  <= '0;
          step_q  <= '0;
          pass_q  <= 1'b0;
          fcode_q <= FC_NONE;
          fail_q  <= '0;
          st_q    <= SQ_CLR;
        end
        SQ_CLR: begin
          step_q <= '0;
          st_q   <= SQ_STEP;
        end
        SQ_STEP: st_q <= SQ_CMP;
        SQ_CMP: begin
          if (mism && !in_setup) begin
            fcode_q <= in_chk ? FC_OUTPUT : FC_TRANSFER;
            fail_q  <= case_q;
            st_q    <= SQ_DONE;
          end else if (last_step) begin
            if (last_case) begin
              pass_q <= 1'b1;
              st_q   <= SQ_DONE;
            end else begin
              case_q <= case_q + 1'b1;
              st_q   <= SQ_CLR;
            end
          end else begin
            step_q <= step_q + 1'b1;
            st_q   <= SQ_STEP;
          end
        end
        default: st_q <= SQ_IDLE;
      endcase
    end
  end

  assign busy_o       = (st_q == SQ_CLR) || (st_q == SQ_STEP) || (st_q == SQ_CMP);
  assign done_o       = (st_q == SQ_DONE);
  assign pass_o       = pass_q;
  assign fault_code_o = fcode_q;
  assign fail_case_o  = fail_q;
endmodule

// File: rtl/fsm_conf_seq_chk.sv
`timescale 1ns/1ps
module fsm_conf_seq_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       mut_clr_o,
  input logic       mut_step_o,
  input logic       busy_o,
  input logic       done_o,
  input logic       pass_o,
  input logic [1:0] fault_code_o
);
  assert_clr_then_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mut_clr_o |=> mut_step_o);
  assert_step_single_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mut_step_o |=> !mut_step_o);
  assert_step_no_clr_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mut_step_o && mut_clr_o));
  assert_fail_code_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !pass_o) |-> (fault_code_o != 2'd0));
  assert_done_quiet_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!mut_step_o && !mut_clr_o));
  assert_busy_done_excl_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(busy_o && done_o));
  assert_pass_code_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && pass_o) |-> (fault_code_o == 2'd0));
endmodule

bind fsm_conf_seq fsm_conf_seq_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .mut_clr_o   (mut_clr_o),
  .mut_step_o  (mut_step_o),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .pass_o      (pass_o),
  .fault_code_o(fault_code_o)
);

// File: tb/fsm_conf_seq_bench.sv
`timescale 1ns/1ps
module fsm_conf_seq_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [1:0] mode = 2'd0;
  logic       clr, sym, step, busy, done, pass;
  logic [1:0] fcode;
  logic [3:0] fcase;
  logic       o_good, o_outf, o_xfer, mut_out;
  int         fsel = 0;
  int         n_chk = 0, n_bad = 0, cyc = 0, nsteps = 0, nclr = 0;
  logic [63:0] symrec;

  always #10 clk = ~clk;

  fsm_mealy_ref #(.FAULT(0)) u_good (.clk_i(clk), .rst_ni(rst_n), .clr_i(clr), .sym_i(sym), .step_i(step), .out_o(o_good));
  fsm_mealy_ref #(.FAULT(1)) u_outf (.clk_i(clk), .rst_ni(rst_n), .clr_i(clr), .sym_i(sym), .step_i(step), .out_o(o_outf));
  fsm_mealy_ref #(.FAULT(2)) u_xfer (.clk_i(clk), .rst_ni(rst_n), .clr_i(clr), .sym_i(sym), .step_i(step), .out_o(o_xfer));
  assign mut_out = (fsel == 0) ? o_good : (fsel == 1) ? o_outf : o_xfer;

  fsm_conf_seq u_fsm_conf_seq (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .mode_i(mode),
    .mut_clr_o(clr), .mut_sym_o(sym), .mut_step_o(step), .mut_out_i(mut_out),
    .busy_o(busy), .done_o(done), .pass_o(pass), .fault_code_o(fcode), .fail_case_o(fcase)
  );

  always @(negedge clk) begin
    cyc++;
    if (step) begin
      if (nsteps < 64) symrec[nsteps] = sym;
      nsteps++;
    end
    if (clr) nclr++;
  end

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    wait (cyc >= 150000);
    n_bad++;
    $display("FAIL watchdog (R10): actual %0d cycles expected fewer than 150000", cyc);
    summary();
  end

  task automatic check(string tag, int act, int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic run(int m, int f, int poke);
    @(negedge clk);
    mode = 2'(m); fsel = f; nsteps = 0; nclr = 0; symrec = '0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int i = 1; i < 4000 && !done; i++) begin
      if (poke != 0 && i == poke) begin start = 1'b1; mode = 2'd2; end
      else start = 1'b0;
      @(negedge clk);
    end
    start = 1'b0;
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    check("R1 busy in reset", int'(busy), 0);
    check("R1 done in reset", int'(done), 0);
    check("R1 pass in reset", int'(pass), 0);
    check("R1 code in reset", int'(fcode), 0);
    check("R1 strobes in reset", int'(clr) + int'(step), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 idle after reset", int'(busy) + int'(done) + int'(step) + int'(clr), 0);
  endtask

  task automatic t_tour();
    run(0, 2, 0);
    check("R4 tour passes transfer fault", int'(pass), 1);
    check("R4 tour symbols ababab", int'(symrec[5:0]), 6'b101010);
    check("R4 tour steps", nsteps, 6);
    check("R2 tour clears", nclr, 1);
    check("R12 tour pass code", int'(fcode), 0);
    run(0, 1, 0);
    check("R8 tour output fault code", int'(fcode), 1);
    check("R8 tour output fault case", int'(fcase), 0);
  endtask

  task automatic t_ds();
    run(1, 0, 0);
    check("R5 ds pass good", int'(pass), 1);
    check("R5 ds steps", nsteps, 24);
    check("R2 ds clears", nclr, 6);
    check("R12 ds pass code", int'(fcode), 0);
    run(1, 2, 0);
    check("R5 ds transfer pass", int'(pass), 0);
    check("R9 ds transfer code", int'(fcode), 2);
    check("R5 ds transfer case", int'(fcase), 5);
    check("R10 ds steps up to failure", nsteps, 24);
    begin
      int s0 = nsteps;
      repeat (10) @(negedge clk);
      check("R10 halted steps", nsteps, s0);
      check("R10 done held", int'(done) * 2 + int'(busy), 2);
    end
    run(1, 1, 0);
    check("R8 ds output fault code", int'(fcode), 1);
    check("R10 ds output fault stops after one step", nsteps, 1);
  endtask

  task automatic t_w();
    run(2, 0, 0);
    check("R6 w pass good", int'(pass), 1);
    check("R6 w steps", nsteps, 36);
    check("R2 w clears", nclr, 12);
    run(2, 2, 0);
    check("R9 w transfer code", int'(fcode), 2);
    check("R6 w transfer case", int'(fcase), 11);
    run(2, 1, 0);
    check("R8 w output fault code", int'(fcode), 1);
    check("R8 w output fault case", int'(fcase), 0);
  endtask

  task automatic t_uio();
    run(3, 0, 0);
    check("R7 uio pass good", int'(pass), 1);
    check("R7 uio steps", nsteps, 20);
    check("R2 uio clears", nclr, 6);
    run(3, 2, 0);
    check("R9 uio transfer code", int'(fcode), 2);
    check("R7 uio transfer case", int'(fcase), 5);
    check("R7 uio steps up to failure", nsteps, 20);
    run(3, 1, 0);
    check("R8 uio output fault code", int'(fcode), 1);
  endtask

  task automatic t_restart_ignored();
    run(1, 0, 5);
    check("R11 second start ignored pass", int'(pass), 1);
    check("R11 second start ignored steps", nsteps, 24);
    check("R11 second start ignored clears", nclr, 6);
  endtask

  initial begin
    t_reset();
    t_tour();
    t_ds();
    t_w();
    t_uio();
    t_restart_ignored();
    summary();
  end
endmodule